// File: doc/BRIEF.md
# Instruction Fetch Breakpoint Comparator Bank

This block holds a small set of code-address comparators. It watches the address of every instruction fetch the processor makes. Each comparator stores a word-aligned compare address, an enable bit and a two-bit mode. The mode chooses between a remap hit and a break on the lower halfword, the upper halfword or both halfwords of the matched word. When an enabled comparator matches a valid fetch in a break mode, the block raises a one-cycle halt request. A matching comparator in remap mode raises a remap flag instead. The patching datapath behind that flag is outside this block.

A control word holds the unit-wide enable. A write to the control word takes effect only when the write also carries a set key bit. The control word also reports, read-only, how many code comparators and literal comparators exist. Software reaches all registers through a word-indexed port. The write side is registered. The read side is combinational.

Top module: `bpcmp_bank`

## Requirements
- R1: After reset, the control word reads with the enable bit (bit 0) at 0. Every comparator word reads 0, and `halt_req`, `remap_hit` and `hit_vec` are low.
- R2: Register index 0 is the control word. Bits [7:4] read NUM_CODE (default 6), bits [11:8] read NUM_LIT (default 2), and every other bit except bit 0 reads 0. The key bit (bit 1) also reads 0.
- R3: A write to index 0 updates the unit enable from bit 0 only when bit 1 of the write data is 1. Otherwise the write has no effect.
- R4: Index k+1 is comparator k. Its layout is mode [31:30], compare address [28:2] and enable [0]. Bits 29 and 1 always read 0, and the other bits read back as written.
- R5: Compare address bits [28:2] must equal fetch address bits [28:2]. Fetch bit 1 then picks the halfword: 0 is lower, 1 is upper. Mode 01 breaks only on the lower halfword, mode 10 only on the upper halfword, and mode 11 on either.
- R6: A comparator can hit only when both the unit enable and its own enable are 1.
- R7: `halt_req` is high for exactly the cycle after a cycle in which `fetch_valid` is high and some comparator breaks. No hit is reported when `fetch_valid` is low.
- R8: Mode 00 never raises `halt_req`. A matching mode-00 comparator sets `remap_hit` in the cycle after the fetch, for either halfword.
- R9: `hit_vec` bit k is high, in the same cycle as `halt_req`, exactly when comparator k caused the break.
- R10: Fetch address bits [31:29] and bit 0 have no effect on matching.
- R11: A fetch is compared against the register contents that were present before any write made in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | RA_W | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| fetch_valid | input | 1 | Instruction fetch valid |
| fetch_addr | input | 32 | Instruction fetch address |
| halt_req | output | 1 | One-cycle halt request |
| remap_hit | output | 1 | Remap-mode comparator matched |
| hit_vec | output | NUM_CODE | Per-comparator break hits |

## Verification
Two things can happen in the same clock edge: a register write and a fetch comparison. The bench drives both together. It disables an armed comparator in the same cycle as a matching fetch, and it enables a comparator in the same cycle as a fetch. The first case must still halt and the second must not, which shows that comparison uses the state before the write. A halt and a remap can also occur in the same cycle. The bench sets one comparator in break mode and another in remap mode on the same word, and expects both outputs high together.

// File: rtl/bpcmp_bank.sv
module bpcmp_bank #(
  parameter int NUM_CODE = 6,
  parameter int NUM_LIT  = 2,
  parameter int RA_W     = $clog2(NUM_CODE + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_we,
  input  logic [RA_W-1:0]     reg_addr,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  input  logic                fetch_valid,
  input  logic [31:0]         fetch_addr,
  output logic                halt_req,
  output logic                remap_hit,
  output logic [NUM_CODE-1:0] hit_vec
);

  logic                unit_en;
  logic [1:0]          mode_q [NUM_CODE];
  logic [26:0]         cadr_q [NUM_CODE];
  logic [NUM_CODE-1:0] en_q;
  logic [NUM_CODE-1:0] brk;
  logic [NUM_CODE-1:0] rmp;

  wire ctrl_wr = reg_we && (reg_addr == '0) && reg_wdata[1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) unit_en <= 1'b0;
    else if (ctrl_wr) unit_en <= reg_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NUM_CODE; k++) begin
        mode_q[k] <= 2'b00;
        cadr_q[k] <= '0;
        en_q[k]   <= 1'b0;
      end
    end else begin
      for (int k = 0; k < NUM_CODE; k++) begin
        if (reg_we && reg_addr == RA_W'(k + 1)) begin
          mode_q[k] <= reg_wdata[31:30];
          cadr_q[k] <= reg_wdata[28:2];
          en_q[k]   <= reg_wdata[0];
        end
      end
    end
  end

  for (genvar i = 0; i < NUM_CODE; i++) begin : g_cmp
    wire amatch = unit_en && en_q[i] && (fetch_addr[28:2] == cadr_q[i]);
    assign brk[i] = amatch && (fetch_addr[1] ? mode_q[i][1] : mode_q[i][0]);
    assign rmp[i] = amatch && (mode_q[i] == 2'b00);
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == '0)
      reg_rdata = {17'd0, 3'd0, 4'(NUM_LIT), 4'(NUM_CODE), 3'd0, unit_en};
    else
      for (int k = 0; k < NUM_CODE; k++)
        if (reg_addr == RA_W'(k + 1))
          reg_rdata = {mode_q[k], 1'b0, cadr_q[k], 1'b0, en_q[k]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt_req  <= 1'b0;
      remap_hit <= 1'b0;
      hit_vec   <= '0;
    end else begin
      halt_req  <= fetch_valid && (|brk);
      remap_hit <= fetch_valid && (|rmp);
      hit_vec   <= fetch_valid ? brk : '0;
    end
  end

endmodule

// File: rtl/bpcmp_bank_chk.sv
module bpcmp_bank_chk #(
  parameter int NUM_CODE = 6,
  parameter int NUM_LIT  = 2,
  parameter int RA_W     = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            reg_we,
  input logic [RA_W-1:0] reg_addr,
  input logic [31:0]     reg_wdata,
  input logic [31:0]     reg_rdata,
  input logic            fetch_valid,
  input logic            halt_req,
  input logic            remap_hit,
  input logic            unit_en
);

  AST_HALT_AFTER_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    halt_req |-> $past(fetch_valid)); // R7

  AST_REMAP_AFTER_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    remap_hit |-> $past(fetch_valid)); // R8

  AST_HALT_NEEDS_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
    halt_req |-> $past(unit_en)); // R6

  AST_KEYLESS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == '0 && !reg_wdata[1]) |=> $stable(unit_en)); // R3

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr != '0) |-> (reg_rdata[29] == 1'b0 && reg_rdata[1] == 1'b0)); // R4

  AST_COUNT_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == '0) |-> (reg_rdata[11:4] == {4'(NUM_LIT), 4'(NUM_CODE)} && reg_rdata[31:12] == 20'd0)); // R2

endmodule

bind bpcmp_bank bpcmp_bank_chk #(.NUM_CODE(NUM_CODE), .NUM_LIT(NUM_LIT), .RA_W(RA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fetch_valid(fetch_valid),
  .halt_req(halt_req), .remap_hit(remap_hit), .unit_en(unit_en)
);

// File: tb/sim_bpcmp_bank.sv
`timescale 1ns/1ps
module sim_bpcmp_bank;
  localparam int NC = 6;
  localparam int NL = 2;
  localparam int RW = $clog2(NC + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_we = 1'b0;
  logic [RW-1:0] reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          fetch_valid = 1'b0;
  logic [31:0]   fetch_addr = '0;
  logic          halt_req, remap_hit;
  logic [NC-1:0] hit_vec;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  bpcmp_bank #(.NUM_CODE(NC), .NUM_LIT(NL)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fetch_valid(fetch_valid),
    .fetch_addr(fetch_addr), .halt_req(halt_req), .remap_hit(remap_hit),
    .hit_vec(hit_vec)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] cword(input logic [1:0] m, input logic [31:0] a, input logic e);
    return {m, 1'b0, a[28:2], 1'b0, e};
  endfunction

  function automatic logic [31:0] base(input int s);
    return 32'h0000_1000 + 32'(s) * 32'h100;
  endfunction

  task automatic wr(input int idx, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = RW'(idx); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input int idx, output logic [31:0] d);
    @(negedge clk);
    reg_addr = RW'(idx);
    #1 d = reg_rdata;
  endtask

  task automatic fetch(input logic [31:0] a);
    @(negedge clk);
    fetch_valid = 1'b1; fetch_addr = a;
    @(negedge clk);
    fetch_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 halt", {29'd0, halt_req, remap_hit, |hit_vec}, 32'd0);
    for (int k = 0; k <= NC; k++) begin
      rd(k, d);
      chk("R1 regs", k == 0 ? {31'd0, d[0]} : d, 32'd0);
    end
    // R2 control field layout
    rd(0, d);
    chk("R2 ctrl", d, {20'd0, 4'(NL), 4'(NC), 4'd0});
    // R3 key protection
    wr(0, 32'h0000_0001);
    rd(0, d); chk("R3 keyless", 32'(d[0]), 32'd0);
    wr(0, 32'h0000_0003);
    rd(0, d); chk("R3 keyed set", d, {20'd0, 4'(NL), 4'(NC), 4'd1});
    wr(0, 32'h0000_0000);
    rd(0, d); chk("R3 keyless clear", 32'(d[0]), 32'd1);
    // R4 readback with reserved bits
    for (int k = 0; k < NC; k++) begin
      wr(k + 1, 32'hFFFF_FFFF ^ (32'(k) << 4));
      rd(k + 1, d);
      chk("R4 readback", d, (32'hFFFF_FFFF ^ (32'(k) << 4)) & 32'hDFFF_FFFD);
      wr(k + 1, 32'd0);
    end

    // R5 R6 R7 R8 R9 R10 sweep
    for (int s = 0; s < NC; s++) begin
      for (int m = 0; m < 4; m++)
        for (int ue = 0; ue < 2; ue++)
          for (int se = 0; se < 2; se++)
            for (int hw = 0; hw < 2; hw++) begin
              logic hit, eb, er;
              logic [31:0] a;
              wr(0, {30'd0, 1'b1, 1'(ue)});
              wr(s + 1, cword(2'(m), base(s), 1'(se)));
              a = {3'(s + 3), base(s)[28:2], 1'(hw), 1'(s & 1)};
              hit = (ue == 1) && (se == 1);
              eb = hit && (hw == 1 ? m[1] : m[0]);
              er = hit && (m == 0);
              fetch(a);
              chk("R5 R6 R10 halt", 32'(halt_req), 32'(eb));
              chk("R8 remap", 32'(remap_hit), 32'(er));
              chk("R9 hitvec", 32'(hit_vec), eb ? (32'd1 << s) : 32'd0);
              @(negedge clk);
              chk("R7 pulse", {30'd0, halt_req, remap_hit}, 32'd0);
              fetch(a ^ 32'h0000_0004);
              chk("R5 miss", {30'd0, halt_req, remap_hit}, 32'd0);
            end
      wr(s + 1, 32'd0);
    end

    // R7 no hit without fetch_valid
    wr(0, 32'd3);
    wr(1, cword(2'b11, base(0), 1'b1));
    @(negedge clk); fetch_addr = base(0); fetch_valid = 1'b0;
    @(negedge clk);
    chk("R7 invalid", {30'd0, halt_req, remap_hit}, 32'd0);

    // R8 R9 break and remap together
    wr(2, cword(2'b00, base(0), 1'b1));
    fetch(base(0));
    chk("R8 both halt", 32'(halt_req), 32'd1);
    chk("R8 both remap", 32'(remap_hit), 32'd1);
    chk("R9 both vec", 32'(hit_vec), 32'd1);
    wr(2, 32'd0);

    // R11 write and fetch in same cycle
    @(negedge clk);
    reg_we = 1'b1; reg_addr = RW'(1); reg_wdata = 32'd0;
    fetch_valid = 1'b1; fetch_addr = base(0);
    @(negedge clk);
    reg_we = 1'b0; fetch_valid = 1'b0;
    chk("R11 old enabled", 32'(halt_req), 32'd1);
    fetch(base(0));
    chk("R11 now disabled", 32'(halt_req), 32'd0);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = RW'(1); reg_wdata = cword(2'b11, base(0), 1'b1);
    fetch_valid = 1'b1; fetch_addr = base(0);
    @(negedge clk);
    reg_we = 1'b0; fetch_valid = 1'b0;
    chk("R11 old disabled", 32'(halt_req), 32'd0);
    fetch(base(0));
    chk("R11 now enabled", 32'(halt_req), 32'd1);

    // R1 reset again clears enables
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd(0, d); chk("R1 reset unit", 32'(d[0]), 32'd0);
    rd(1, d); chk("R1 reset slot", d, 32'd0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule